// File: doc/BRIEF.md
# Dual-Encoding Serial Clock Divider

This block produces the bit clock of a synchronous serial audio port by dividing its source clock by a programmable ratio. Software loads a divider field together with an encoding select. In the legacy encoding only even ratios are possible and the field is narrow. In the extended encoding every integer ratio up to 4096 is possible and the field is wider. The block also returns the ratio it has decoded, so software can read back the divide value that is in effect.

Configuration is accepted only while the port is disabled. While the port is disabled the bit clock is held low. When the port is enabled the divider starts from a known phase. Single-cycle rise and fall strobes mark every bit clock transition, so logic downstream can shift data on the source clock without detecting edges itself.

Top module: `bitclk_divider`

## Requirements
- R1: With extMode=0 latched, the ratio is cfgField[7:0]*2+2 (even values 2..512). cfgField[11:8] are ignored. After reset the latched field is 0 in legacy mode, so ratio reads 2.
- R2: With extMode=1 latched, the ratio is cfgField[11:0]+1 (1..4096).
- R3: A write (cfgWe=1) takes effect at the clock edge only if portEn=0. A write made while portEn=1 leaves ratio unchanged.
- R4: While portEn=0, bitClk is low and the phase counter is cleared. Each new enable therefore restarts from the same phase.
- R5: With ratio N>=2, counting from the first edge at which portEn is sampled high as edge 1, bitClk first rises after edge floor(N/2).
- R6: With ratio N>=2, bitClk has period N source cycles, with a low phase of floor(N/2) and a high phase of ceil(N/2). After edge k it is high exactly when (k mod N) >= floor(N/2).
- R7: With ratio 1, bitClk equals srcClk while enabled, and both strobes stay high after every enabled edge.
- R8: riseStb is high for exactly the cycles in which bitClk has just risen (k mod N == floor(N/2)).
- R9: fallStb is high for exactly the cycles in which bitClk has just fallen. This includes the fall forced when the port is disabled while bitClk is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| portEn | input | 1 | Port enable; the divider runs only while this is high |
| extMode | input | 1 | Encoding select captured on a write: 0 legacy, 1 extended |
| cfgWe | input | 1 | Configuration write strobe |
| cfgField | input | 12 | Control-word divider bits 19:8 (legacy uses the low 8) |
| bitClk | output | 1 | Divided serial bit clock |
| riseStb | output | 1 | One-cycle pulse when bitClk has just risen |
| fallStb | output | 1 | One-cycle pulse when bitClk has just fallen |
| ratio | output | 13 | Decoded effective divide ratio |

## Verification
The case that is hardest to reach from the ports is a disable that arrives while the bit clock is high. It must force a fall strobe and leave the counter cleared, and the proof that the counter was cleared can only come from the next enable. The bench runs a ratio-6 clock into its high phase, drops the enable, checks the forced fall, and then re-enables and measures whether the first rise again comes after three edges. The odd-ratio asymmetry and the ratio-1 bypass are checked in separate directed tasks. In the bypass task the output is sampled in both halves of the source clock.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef struct packed {
    logic hold;     // port disabled: clear phase
    logic toHigh;   // drive bit clock high at next edge
    logic toLow;    // drive bit clock low at next edge
    logic bypass;   // ratio of one, source passes through
  } ctrlStb_t;
endpackage

// File: rtl/bcd_cfg.sv
module bcd_cfg #(
  parameter int LEG_W   = 8,
  parameter int EXT_W   = 12,
  parameter int RATIO_W = EXT_W + 1
) (
  input  logic               srcClk,
  input  logic               rstN,
  input  logic               portEn,
  input  logic               extMode,
  input  logic               cfgWe,
  input  logic [EXT_W-1:0]   cfgField,
  output logic [RATIO_W-1:0] ratio
);
  logic [EXT_W-1:0] fieldQ;
  logic             extQ;
  logic [RATIO_W-1:0] legRatio, extRatio;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      fieldQ <= '0;
      extQ   <= 1'b0;
    end else if (cfgWe && !portEn) begin
      fieldQ <= cfgField;
      extQ   <= extMode;
    end
  end

  always_comb begin
    legRatio = RATIO_W'({fieldQ[LEG_W-1:0], 1'b0}) + RATIO_W'(2);
    extRatio = RATIO_W'(fieldQ) + RATIO_W'(1);
    ratio    = extQ ? extRatio : legRatio;
  end

  p_ignore_write_r3: assert property (@(posedge srcClk) disable iff (!rstN)
    portEn |=> $stable(ratio));
  p_legacy_even_r1: assert property (@(posedge srcClk) disable iff (!rstN)
    !extQ |-> (ratio[0] == 1'b0 && ratio >= RATIO_W'(2)));
endmodule

// File: rtl/bcd_ctrl.sv
module bcd_ctrl
  import bcd_pkg::*;
#(
  parameter int RATIO_W = 13
) (
  input  logic               srcClk,
  input  logic               rstN,
  input  logic               portEn,
  input  logic [RATIO_W-1:0] ratio,
  output ctrlStb_t           stb
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] lowLen;
  logic               isByp, run;

  always_comb begin
    lowLen     = ratio >> 1;
    isByp      = (ratio == RATIO_W'(1));
    run        = portEn && !isByp;
    stb.hold   = !portEn;
    stb.bypass = isByp;
    stb.toHigh = run && (cnt == lowLen - RATIO_W'(1));
    stb.toLow  = run && (cnt == ratio - RATIO_W'(1));
  end

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN)                             cnt <= '0;
    else if (!run)                         cnt <= '0;
    else if (cnt == ratio - RATIO_W'(1))   cnt <= '0;
    else                                   cnt <= cnt + RATIO_W'(1);
  end

  p_clear_when_off_r4: assert property (@(posedge srcClk) disable iff (!rstN)
    !portEn |=> cnt == '0);
  p_cnt_range_r6: assert property (@(posedge srcClk) disable iff (!rstN)
    run |-> cnt < ratio);
  p_strobe_excl_r6: assert property (@(posedge srcClk) disable iff (!rstN)
    $onehot0({stb.toHigh, stb.toLow}));
endmodule

// File: rtl/bcd_datapath.sv
module bcd_datapath
  import bcd_pkg::*;
(
  input  logic     srcClk,
  input  logic     rstN,
  input  logic     portEn,
  input  ctrlStb_t stb,
  output logic     bitClk,
  output logic     riseStb,
  output logic     fallStb
);
  logic divClk, riseQ, fallQ;
  logic bypRun;

  assign bypRun = stb.bypass && !stb.hold;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      divClk <= 1'b0;
      riseQ  <= 1'b0;
      fallQ  <= 1'b0;
    end else begin
      if (stb.hold)        divClk <= 1'b0;
      else if (stb.toHigh) divClk <= 1'b1;
      else if (stb.toLow)  divClk <= 1'b0;
      riseQ <= stb.toHigh || bypRun;
      fallQ <= stb.toLow || (stb.hold && divClk) || bypRun;
    end
  end

  assign bitClk  = stb.bypass ? (srcClk && portEn) : divClk;
  assign riseStb = riseQ;
  assign fallStb = fallQ;

  p_rise_aligned_r8: assert property (@(posedge srcClk) disable iff (!rstN)
    $rose(divClk) |-> riseQ);
  p_fall_aligned_r9: assert property (@(posedge srcClk) disable iff (!rstN)
    $fell(divClk) |-> fallQ);
  p_low_when_off_r4: assert property (@(posedge srcClk) disable iff (!rstN)
    !portEn |=> !divClk);
endmodule

// File: rtl/bitclk_divider.sv
module bitclk_divider
  import bcd_pkg::*;
#(
  parameter int LEG_W   = 8,
  parameter int EXT_W   = 12,
  localparam int RATIO_W = EXT_W + 1
) (
  input  logic               srcClk,
  input  logic               rstN,
  input  logic               portEn,
  input  logic               extMode,
  input  logic               cfgWe,
  input  logic [EXT_W-1:0]   cfgField,
  output logic               bitClk,
  output logic               riseStb,
  output logic               fallStb,
  output logic [RATIO_W-1:0] ratio
);
  ctrlStb_t stb;

  bcd_cfg #(.LEG_W(LEG_W), .EXT_W(EXT_W), .RATIO_W(RATIO_W)) u_cfg (
    .srcClk(srcClk), .rstN(rstN), .portEn(portEn), .extMode(extMode),
    .cfgWe(cfgWe), .cfgField(cfgField), .ratio(ratio));

  bcd_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .srcClk(srcClk), .rstN(rstN), .portEn(portEn), .ratio(ratio), .stb(stb));

  bcd_datapath u_dp (
    .srcClk(srcClk), .rstN(rstN), .portEn(portEn), .stb(stb),
    .bitClk(bitClk), .riseStb(riseStb), .fallStb(fallStb));
endmodule

// File: tb/bitclk_divider_tb.sv
module bitclk_divider_tb;
  logic        srcClk = 1'b0;
  logic        rstN = 1'b0;
  logic        portEn = 1'b0;
  logic        extMode = 1'b0;
  logic        cfgWe = 1'b0;
  logic [11:0] cfgField = '0;
  logic        bitClk, riseStb, fallStb;
  logic [12:0] ratio;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  bitclk_divider u_dut (
    .srcClk(srcClk), .rstN(rstN), .portEn(portEn), .extMode(extMode),
    .cfgWe(cfgWe), .cfgField(cfgField), .bitClk(bitClk),
    .riseStb(riseStb), .fallStb(fallStb), .ratio(ratio));

  always #10 srcClk = ~srcClk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic ext, input logic [11:0] fld);
    @(negedge srcClk);
    cfgWe = 1'b1; extMode = ext; cfgField = fld;
    @(negedge srcClk);
    cfgWe = 1'b0;
  endtask

  // Enables the port and checks 3 periods of bitClk and strobes.
  task automatic runDiv(input string tag, input int n);
    int lo = n / 2;
    @(negedge srcClk);
    portEn = 1'b1;
    for (int k = 1; k <= 3 * n; k++) begin
      @(posedge srcClk); #5;
      chk({tag, " R5/R6 bitClk"}, int'(bitClk), int'((k % n) >= lo));
      chk({tag, " R8 riseStb"}, int'(riseStb), int'((k % n) == lo));
      chk({tag, " R9 fallStb"}, int'(fallStb), int'((k % n) == 0));
    end
    @(negedge srcClk);
    portEn = 1'b0;
    @(negedge srcClk);
  endtask

  task automatic t_reset();
    #5;
    chk("R4 bitClk in reset", int'(bitClk), 0);
    chk("R1 reset ratio", int'(ratio), 2);
    @(negedge srcClk); rstN = 1'b1;
    @(posedge srcClk); #5;
    chk("R4 bitClk idle", int'(bitClk), 0);
    chk("R8 riseStb idle", int'(riseStb), 0);
    chk("R9 fallStb idle", int'(fallStb), 0);
  endtask

  task automatic t_legacy();
    writeCfg(1'b0, 12'h0FF); chk("R1 legacy max", int'(ratio), 512);
    writeCfg(1'b0, 12'hF03); chk("R1 legacy upper bits ignored", int'(ratio), 8);
    writeCfg(1'b0, 12'h000); chk("R1 legacy min", int'(ratio), 2);
    runDiv("legacy2", 2);
    writeCfg(1'b0, 12'h005); chk("R1 legacy 12", int'(ratio), 12);
    runDiv("legacy12", 12);
  endtask

  task automatic t_ext();
    writeCfg(1'b1, 12'hF03); chk("R2 ext wide", int'(ratio), 3844);
    writeCfg(1'b1, 12'hFFF); chk("R2 ext max", int'(ratio), 4096);
    writeCfg(1'b1, 12'h004); chk("R2 ext 5", int'(ratio), 5);
    runDiv("ext5", 5);
    writeCfg(1'b1, 12'h002); chk("R2 ext 3", int'(ratio), 3);
    runDiv("ext3", 3);
  endtask

  task automatic t_ignore();
    writeCfg(1'b1, 12'h009);
    @(negedge srcClk); portEn = 1'b1;
    writeCfg(1'b0, 12'h040);
    chk("R3 write while enabled ignored", int'(ratio), 10);
    @(negedge srcClk); portEn = 1'b0;
    @(negedge srcClk);
    chk("R3 ratio kept after disable", int'(ratio), 10);
  endtask

  task automatic t_bypass();
    writeCfg(1'b1, 12'h000); chk("R2 ext 1", int'(ratio), 1);
    @(posedge srcClk); #5;
    chk("R7 bypass off low", int'(bitClk), 0);
    @(negedge srcClk); portEn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge srcClk); #5;
      chk("R7 bypass high half", int'(bitClk), 1);
      chk("R7 bypass riseStb", int'(riseStb), 1);
      chk("R7 bypass fallStb", int'(fallStb), 1);
      @(negedge srcClk); #5;
      chk("R7 bypass low half", int'(bitClk), 0);
    end
    @(negedge srcClk); portEn = 1'b0;
    @(negedge srcClk);
  endtask

  task automatic t_disable_high();
    writeCfg(1'b0, 12'h002); chk("R1 legacy 6", int'(ratio), 6);
    @(negedge srcClk); portEn = 1'b1;
    for (int k = 1; k <= 4; k++) @(posedge srcClk);
    #5;
    chk("R6 high before disable", int'(bitClk), 1);
    @(negedge srcClk); portEn = 1'b0;
    @(posedge srcClk); #5;
    chk("R4 low after disable", int'(bitClk), 0);
    chk("R9 forced fall strobe", int'(fallStb), 1);
    @(posedge srcClk); #5;
    chk("R9 fall strobe single", int'(fallStb), 0);
    runDiv("restart6 R4", 6);
  endtask

  initial begin
    t_reset();
    t_legacy();
    t_ext();
    t_ignore();
    t_bypass();
    t_disable_high();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule